// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 32-bit operands and folds the product into one of four 48-bit accumulators. A four-bit mode field selects how the numbers are read: unsigned integer, signed integer or signed fraction. It also enables saturation and, for fractions, rounding. An operand may be taken whole or cut down to one of its 16-bit halves. In the integer modes the product may be doubled or halved before it is accumulated. Products and sums that leave their legal range raise an overflow. Each accumulator keeps a sticky overflow bit. When saturation is enabled, an overflowed result is clamped, and later operations on an accumulator whose sticky bit is set are skipped.

A caller writes the mode, then pulses `start` for one cycle with the operands and controls. One cycle later `done` pulses. At that point `acc_q` shows the new value of the addressed accumulator and `status_q` shows the recomputed flags. The sticky bits clear only on reset.

Top module: `mac_sat_unit`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle in which `start` was sampled high. `acc_q` and the flag bits change only on that cycle and hold otherwise.
- R2: `status_q` packs bit 0 EV, bit 1 V, bit 2 Z, bit 3 N, bit 4 RT, bit 5 FI, bit 6 SU, bit 7 OMC, and bits 8..11 the sticky bits of accumulators 0..3. Reset clears it all. A `cfg_we` pulse copies `cfg_mode` ({OMC,SU,FI,RT}) into bits 7:4 on the next cycle.
- R3: With `word_en`, each operand is reduced to its high half (select=1) or low half (select=0). That half is placed in bits 31:16 over zeros in fractional mode (FI=1), sign-extended in signed mode (SU=1) and zero-extended otherwise.
- R4: Unsigned mode: a product wider than 40 bits raises V. With OMC the product is forced to 2^50; without it the product is cut to its low 40 bits.
- R5: Signed mode: a product outside the 40-bit signed range raises V. With OMC it is forced to a same-signed value of magnitude about 2^50.
- R6: Fractional mode: the signed product is shifted right arithmetically by 24. With RT set, the dropped 24 bits round to nearest, and a tie (0x800000) rounds to the even result.
- R7: In the integer modes `shift_sel`=1 doubles the product and 3 halves it; other codes, and any code in fractional mode, leave the product unchanged.
- R8: Signed mode: a sum outside the 48-bit signed range raises V. Any V sets the sticky bit of the target accumulator. With OMC an overflowed result becomes 0x0000_7FFF_FFFF, or 0xFFFF_8000_0000 if the true sum is negative.
- R9: Fractional mode uses the 48-bit signed overflow check. With OMC it clamps to 0x7FFF_FFFF_FFFF or 0x8000_0000_0000.
- R10: Unsigned mode: a sum below zero or at or above 2^48 raises V. With OMC the result is 0 for a negative sum and 0xFFFF_FFFF_FFFF otherwise; without OMC it wraps to 48 bits.
- R11: With OMC set and the target sticky bit set, the operation leaves the accumulator and sticky bits unchanged.
- R12: After each operation Z is set when the accumulator is zero, N equals its bit 47, and V equals its sticky bit.
- R13: EV is set when the accumulator is not a sign extension of its low 40 bits (fractional mode) or of its low 32 bits (signed mode), or, in unsigned mode, when any bit above 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 4 | New mode {OMC,SU,FI,RT} |
| start | input | 1 | Begin one multiply-accumulate |
| acc_idx | input | 2 | Target accumulator |
| sub_en | input | 1 | 1 subtracts the product, 0 adds it |
| word_en | input | 1 | Use 16-bit halves of the operands |
| a_hi | input | 1 | Take the upper half of `op_a` in word mode |
| b_hi | input | 1 | Take the upper half of `op_b` in word mode |
| shift_sel | input | 2 | Product shift code (integer modes) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| acc_q | output | 48 | Updated value of the target accumulator |
| status_q | output | 12 | Flags, mode and sticky overflow bits |

## Verification
The hardest situations to reach are the ones where the accumulated sum itself overflows 48 bits while every single product stays inside its legal range. No single operation can get there. The stimulus therefore repeats a product just under 2^39 in signed mode, and a product near 2^38 in fractional mode with saturation, hundreds of times into one accumulator. This walks the sum across the boundary, produces the clamp, and is followed by skipped operations. A behavioural model in the bench checks every intermediate step.

// File: rtl/mac_sat_pkg.sv
`timescale 1ns/1ps
package mac_sat_pkg;
  typedef struct packed {
    logic omc;
    logic su;
    logic fi;
    logic rt;
  } mac_mode_t;

  localparam logic [1:0] SHIFT_LEFT  = 2'd1;
  localparam logic [1:0] SHIFT_RIGHT = 2'd3;
endpackage

// File: rtl/mac_opnd_prep.sv
`timescale 1ns/1ps
module mac_opnd_prep
  import mac_sat_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic [OPW-1:0] raw_i,
  input  logic           word_i,
  input  logic           hi_i,
  input  mac_mode_t      mode_i,
  output logic [OPW-1:0] opnd_o
);
  localparam int HW = OPW / 2;

  logic [HW-1:0] half;

  always_comb begin
    half = hi_i ? raw_i[OPW-1:HW] : raw_i[HW-1:0];
    if (!word_i)          opnd_o = raw_i;
    else if (mode_i.fi)   opnd_o = {half, {HW{1'b0}}};
    else if (mode_i.su)   opnd_o = {{HW{half[HW-1]}}, half};
    else                  opnd_o = {{HW{1'b0}}, half};
  end
endmodule

// File: rtl/mac_product.sv
`timescale 1ns/1ps
module mac_product
  import mac_sat_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int ACCW  = 48,
  parameter int PRODW = 40
) (
  input  logic [OPW-1:0]   a_i,
  input  logic [OPW-1:0]   b_i,
  input  mac_mode_t        mode_i,
  input  logic [1:0]       shift_i,
  output logic [2*OPW-1:0] prod_o,
  output logic             ovf_o
);
  localparam int WW  = 2 * OPW;
  localparam int FSH = WW - PRODW;
  localparam logic [FSH-1:0] HALF = {1'b1, {(FSH-1){1'b0}}};
  localparam logic [WW-1:0]  BIG  = {{(WW-ACCW-3){1'b0}}, 1'b1, {(ACCW+2){1'b0}}};

  logic [WW-1:0]  sprod, uprod, frac_p, int_p;
  logic [FSH-1:0] rem;
  logic           s_fits;

  always_comb begin
    sprod  = {{OPW{a_i[OPW-1]}}, a_i} * {{OPW{b_i[OPW-1]}}, b_i};
    uprod  = {{OPW{1'b0}}, a_i} * {{OPW{1'b0}}, b_i};
    rem    = sprod[FSH-1:0];
    frac_p = {{FSH{sprod[WW-1]}}, sprod[WW-1:FSH]};
    if (mode_i.rt && ((rem > HALF) || ((rem == HALF) && frac_p[0])))
      frac_p = frac_p + {{(WW-1){1'b0}}, 1'b1};

    s_fits = (&sprod[WW-1:PRODW-1]) | (~|sprod[WW-1:PRODW-1]);
    ovf_o  = 1'b0;
    int_p  = '0;
    if (mode_i.su) begin
      int_p = sprod;
      if (!s_fits) begin
        ovf_o = 1'b1;
        if (mode_i.omc) int_p = sprod[WW-1] ? ~BIG : BIG;
      end
    end else begin
      int_p = uprod;
      if (|uprod[WW-1:PRODW]) begin
        ovf_o = 1'b1;
        int_p = mode_i.omc ? BIG : {{(WW-PRODW){1'b0}}, uprod[PRODW-1:0]};
      end
    end
    case (shift_i)
      SHIFT_LEFT:  int_p = {int_p[WW-2:0], 1'b0};
      SHIFT_RIGHT: int_p = {mode_i.su & int_p[WW-1], int_p[WW-1:1]};
      default: ;
    endcase

    if (mode_i.fi) begin
      prod_o = frac_p;
      ovf_o  = 1'b0;
    end else begin
      prod_o = int_p;
    end
  end
endmodule

// File: rtl/mac_accum_sat.sv
`timescale 1ns/1ps
module mac_accum_sat
  import mac_sat_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int ACCW = 48
) (
  input  logic [ACCW-1:0]  acc_i,
  input  logic [2*OPW-1:0] prod_i,
  input  logic             sub_i,
  input  mac_mode_t        mode_i,
  input  logic             mul_ovf_i,
  output logic [ACCW-1:0]  acc_o,
  output logic             ovf_o
);
  localparam int WW = 2 * OPW;
  localparam logic [ACCW-1:0] S_MAX = {{(ACCW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
  localparam logic [ACCW-1:0] S_MIN = ~S_MAX;
  localparam logic [ACCW-1:0] F_MAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] F_MIN = ~F_MAX;

  logic          signed_md, sum_ovf;
  logic [WW-1:0] acc_ext, sum;

  always_comb begin
    signed_md = mode_i.su | mode_i.fi;
    acc_ext   = signed_md ? {{(WW-ACCW){acc_i[ACCW-1]}}, acc_i}
                          : {{(WW-ACCW){1'b0}}, acc_i};
    sum       = sub_i ? (acc_ext - prod_i) : (acc_ext + prod_i);
    if (signed_md)
      sum_ovf = ~((&sum[WW-1:ACCW-1]) | (~|sum[WW-1:ACCW-1]));
    else
      sum_ovf = |sum[WW-1:ACCW];
    ovf_o = mul_ovf_i | sum_ovf;
    acc_o = sum[ACCW-1:0];
    if (ovf_o && mode_i.omc) begin
      if (mode_i.fi)      acc_o = sum[WW-1] ? F_MIN : F_MAX;
      else if (mode_i.su) acc_o = sum[WW-1] ? S_MIN : S_MAX;
      else                acc_o = sum[WW-1] ? '0 : '1;
    end
  end
endmodule

// File: rtl/mac_sat_unit.sv
`timescale 1ns/1ps
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int ACCW  = 48,
  parameter int PRODW = 40,
  parameter int NACC  = 4,
  localparam int AIW  = $clog2(NACC),
  localparam int SW   = NACC + 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_mode,
  input  logic            start,
  input  logic [AIW-1:0]  acc_idx,
  input  logic            sub_en,
  input  logic            word_en,
  input  logic            a_hi,
  input  logic            b_hi,
  input  logic [1:0]      shift_sel,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  output logic            done,
  output logic [ACCW-1:0] acc_q,
  output logic [SW-1:0]   status_q
);
  localparam int WW = 2 * OPW;

  logic [ACCW-1:0] acc_mem [NACC];
  logic [NACC-1:0] sticky_r, sticky_next;
  mac_mode_t       mode_r;
  logic [3:0]      flags_r, flags_next;

  logic [OPW-1:0]  raw [2];
  logic [OPW-1:0]  opnd [2];
  logic            sel_hi [2];
  logic [WW-1:0]   prod;
  logic            mul_ovf, sum_ovf, skip, ev;
  logic [ACCW-1:0] acc_cur, acc_new, acc_next;

  assign raw[0]    = op_a;
  assign raw[1]    = op_b;
  assign sel_hi[0] = a_hi;
  assign sel_hi[1] = b_hi;

  for (genvar g = 0; g < 2; g++) begin : g_prep
    mac_opnd_prep #(.OPW(OPW)) u_prep (
      .raw_i  (raw[g]),
      .word_i (word_en),
      .hi_i   (sel_hi[g]),
      .mode_i (mode_r),
      .opnd_o (opnd[g])
    );
  end

  mac_product #(.OPW(OPW), .ACCW(ACCW), .PRODW(PRODW)) u_mul (
    .a_i     (opnd[0]),
    .b_i     (opnd[1]),
    .mode_i  (mode_r),
    .shift_i (shift_sel),
    .prod_o  (prod),
    .ovf_o   (mul_ovf)
  );

  assign acc_cur = acc_mem[acc_idx];

  mac_accum_sat #(.OPW(OPW), .ACCW(ACCW)) u_acc (
    .acc_i     (acc_cur),
    .prod_i    (prod),
    .sub_i     (sub_en),
    .mode_i    (mode_r),
    .mul_ovf_i (mul_ovf),
    .acc_o     (acc_new),
    .ovf_o     (sum_ovf)
  );

  always_comb begin
    skip        = mode_r.omc & sticky_r[acc_idx];
    acc_next    = skip ? acc_cur : acc_new;
    sticky_next = sticky_r;
    if (sum_ovf && !skip) sticky_next[acc_idx] = 1'b1;
    if (mode_r.fi)
      ev = ~((&acc_next[ACCW-1:PRODW-1]) | (~|acc_next[ACCW-1:PRODW-1]));
    else if (mode_r.su)
      ev = ~((&acc_next[ACCW-1:OPW-1]) | (~|acc_next[ACCW-1:OPW-1]));
    else
      ev = |acc_next[ACCW-1:OPW];
    flags_next = {acc_next[ACCW-1], (acc_next == '0), sticky_next[acc_idx], ev};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NACC; i++) acc_mem[i] <= '0;
      sticky_r <= '0;
      mode_r   <= '0;
      flags_r  <= '0;
      acc_q    <= '0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (cfg_we) mode_r <= mac_mode_t'(cfg_mode);
      if (start) begin
        acc_mem[acc_idx] <= acc_next;
        sticky_r         <= sticky_next;
        flags_r          <= flags_next;
        acc_q            <= acc_next;
      end
    end
  end

  assign status_q = {sticky_r, mode_r, flags_r};
endmodule

// File: rtl/mac_sat_unit_chk.sv
`timescale 1ns/1ps
module mac_sat_unit_chk #(
  parameter int ACCW = 48,
  parameter int NACC = 4,
  localparam int AIW = $clog2(NACC),
  localparam int SW  = NACC + 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [3:0]      cfg_mode,
  input logic            start,
  input logic [AIW-1:0]  acc_idx,
  input logic            done,
  input logic [ACCW-1:0] acc_q,
  input logic [SW-1:0]   status_q
);
  logic [NACC-1:0] stk;
  assign stk = status_q[SW-1:8];

  p_done_follows_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  p_outputs_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(acc_q) && $stable(status_q[3:0])));
  p_mode_write_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (status_q[7:4] == $past(cfg_mode)));
  p_sticky_keep_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stk & $past(stk)) == $past(stk)));
  p_zero_flag_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (status_q[2] == (acc_q == '0)));
  p_neg_flag_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (status_q[3] == acc_q[ACCW-1]));
  p_ovf_flag_r12: assert property (@(posedge clk) disable iff (rst)
    start |=> (status_q[1] == stk[$past(acc_idx)]));
  p_skip_keeps_v_r11: assert property (@(posedge clk) disable iff (rst)
    (start && status_q[7] && stk[acc_idx]) |=> status_q[1]);
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.ACCW(ACCW), .NACC(NACC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_mode (cfg_mode),
  .start    (start),
  .acc_idx  (acc_idx),
  .done     (done),
  .acc_q    (acc_q),
  .status_q (status_q)
);

// File: tb/mac_sat_unit_test.sv
`timescale 1ns/1ps
module mac_sat_unit_test;
  localparam int ACCW = 48;
  localparam int NACC = 4;
  localparam int SW   = NACC + 8;
  localparam longint P31 = 64'sd1 <<< 31;
  localparam longint P32 = 64'sd1 <<< 32;
  localparam longint P39 = 64'sd1 <<< 39;
  localparam longint P47 = 64'sd1 <<< 47;
  localparam longint P48 = 64'sd1 <<< 48;
  localparam longint P50 = 64'sd1 <<< 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cfg_we = 0, start = 0, sub_en = 0, word_en = 0, a_hi = 0, b_hi = 0;
  logic [3:0]  cfg_mode = 0;
  logic [1:0]  acc_idx = 0, shift_sel = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic            done;
  logic [ACCW-1:0] acc_q;
  logic [SW-1:0]   status_q;

  mac_sat_unit uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .start(start),
    .acc_idx(acc_idx), .sub_en(sub_en), .word_en(word_en), .a_hi(a_hi), .b_hi(b_hi),
    .shift_sel(shift_sel), .op_a(op_a), .op_b(op_b),
    .done(done), .acc_q(acc_q), .status_q(status_q)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  logic [ACCW-1:0] ref_acc [NACC];
  logic [NACC-1:0] ref_stk = '0;
  logic [3:0]      ref_mode = '0;
  logic [ACCW-1:0] pend_acc = '0, exp_acc = '0;
  logic [SW-1:0]   pend_stat = '0, exp_stat = '0;
  logic            exp_done = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] prep(logic [31:0] x, logic wd, logic hi, logic [3:0] md);
    logic [15:0] h;
    h = hi ? x[31:16] : x[15:0];
    if (!wd)   return x;
    if (md[1]) return {h, 16'h0};
    if (md[2]) return {{16{h[15]}}, h};
    return {16'h0, h};
  endfunction

  // Behavioural reference: integer arithmetic on 64-bit values.
  task automatic model_op(logic [1:0] idx, logic sb, logic wd, logic ah, logic bh,
                          logic [1:0] sh, logic [31:0] a, logic [31:0] b);
    logic rt, fi, su, omc, ov, ev;
    logic [31:0] xa, xb;
    logic [63:0] u;
    longint p, s, rem, av, sv;
    logic [ACCW-1:0] res;
    rt = ref_mode[0]; fi = ref_mode[1]; su = ref_mode[2]; omc = ref_mode[3];
    ov = 0;
    res = ref_acc[idx];
    if (!(omc && ref_stk[idx])) begin
      xa = prep(a, wd, ah, ref_mode);
      xb = prep(b, wd, bh, ref_mode);
      if (fi) begin
        p = longint'($signed(xa)) * longint'($signed(xb));
        rem = p & 64'sh FFFFFF;
        p = p >>> 24;
        if (rt && (rem > 64'sh800000 || (rem == 64'sh800000 && p[0]))) p = p + 1;
      end else if (su) begin
        p = longint'($signed(xa)) * longint'($signed(xb));
        if (p >= P39 || p < -P39) begin
          ov = 1;
          if (omc) p = (p < 0) ? ~P50 : P50;
        end
      end else begin
        u = {32'h0, xa} * {32'h0, xb};
        p = longint'(u);
        if ((u >> 40) != 0) begin
          ov = 1;
          p = omc ? P50 : longint'(u & 64'hFF_FFFF_FFFF);
        end
      end
      if (!fi && sh == 2'd1) p = p * 2;
      if (!fi && sh == 2'd3) p = p >>> 1;
      av = (fi || su) ? longint'($signed(ref_acc[idx])) : longint'({16'h0, ref_acc[idx]});
      s = sb ? av - p : av + p;
      if (fi || su) begin
        if (s >= P47 || s < -P47) ov = 1;
      end else begin
        if (s < 0 || s >= P48) ov = 1;
      end
      res = s[ACCW-1:0];
      if (ov) begin
        ref_stk[idx] = 1'b1;
        if (omc) begin
          if (fi)      res = (s < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
          else if (su) res = (s < 0) ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
          else         res = (s < 0) ? 48'h0 : 48'hFFFF_FFFF_FFFF;
        end
      end
      ref_acc[idx] = res;
    end
    sv = longint'($signed(res));
    if (fi)      ev = (sv >= P39 || sv < -P39);
    else if (su) ev = (sv >= P31 || sv < -P31);
    else         ev = (longint'({16'h0, res}) >= P32);
    pend_acc  = res;
    pend_stat = {ref_stk, ref_mode, res[ACCW-1], (res == 0), ref_stk[idx], ev};
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_done <= 0; exp_acc <= '0; exp_stat <= '0;
    end else begin
      exp_done <= start;
      if (start) begin
        exp_acc  <= pend_acc;
        exp_stat <= pend_stat;
      end
      if (cfg_we) exp_stat[7:4] <= cfg_mode;
    end
  end

  // Compare against the model on every clock.
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      check("R1 done", {63'h0, done}, {63'h0, exp_done});
      check("R1 acc", {16'h0, acc_q}, {16'h0, exp_acc});
      check("R2 status", {52'h0, status_q}, {52'h0, exp_stat});
    end
  end

  task automatic issue(logic [1:0] idx, logic sb, logic wd, logic ah, logic bh,
                       logic [1:0] sh, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    acc_idx = idx; sub_en = sb; word_en = wd; a_hi = ah; b_hi = bh;
    shift_sel = sh; op_a = a; op_b = b; start = 1;
    model_op(idx, sb, wd, ah, bh, sh, a, b);
    @(negedge clk);
    start = 0;
  endtask

  task automatic set_mode(logic [3:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m; ref_mode = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    for (int i = 0; i < NACC; i++) ref_acc[i] = '0;
    ref_stk = '0; ref_mode = '0; pend_acc = '0; pend_stat = '0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errs++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NACC; i++) ref_acc[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R2 reset status", {52'h0, status_q}, 64'h0);
    check("R1 reset done", {63'h0, done}, 64'h0);

    // Unsigned integer mode
    set_mode(4'b0000);
    issue(0, 0, 0, 0, 0, 0, 32'd3, 32'd5);
    check("R12 add", {16'h0, acc_q}, 64'd15);
    issue(0, 1, 0, 0, 0, 0, 32'd3, 32'd5);
    check("R12 Z flag", {60'h0, status_q[3:0]}, 64'h4);
    issue(0, 0, 0, 0, 0, 1, 32'd3, 32'd5);
    check("R7 shift left", {16'h0, acc_q}, 64'd30);
    issue(1, 0, 0, 0, 0, 3, 32'd7, 32'd1);
    check("R7 shift right", {16'h0, acc_q}, 64'd3);
    issue(2, 0, 1, 1, 0, 0, 32'h0002_0003, 32'h0005_0007);
    check("R3 word halves", {16'h0, acc_q}, 64'd14);
    issue(3, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R4 truncate", {16'h0, acc_q}, 64'h00FE_0000_0001);
    check("R13 EV unsigned", {52'h0, status_q}, 64'h803);

    // Signed integer mode
    set_mode(4'b0100);
    check("R2 mode field", {60'h0, status_q[7:4]}, 64'h4);
    issue(1, 0, 0, 0, 0, 0, 32'hFFFF_FFFD, 32'd7);
    check("R5 signed product", {16'h0, acc_q}, 64'hFFFF_FFFF_FFEE);
    check("R12 N flag", {60'h0, status_q[3:0]}, 64'h8);
    issue(0, 0, 0, 0, 0, 0, 32'h4000_0000, 32'd4);
    check("R13 EV signed", {60'h0, status_q[3:0]}, 64'h1);
    issue(2, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check("R5 product overflow V", {63'h0, status_q[1]}, 64'h1);
    check("R8 sticky set", {63'h0, status_q[10]}, 64'h1);

    // Signed with saturation
    do_reset();
    set_mode(4'b1100);
    issue(0, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check("R8 clamp positive", {16'h0, acc_q}, 64'h0000_7FFF_FFFF);
    check("R8 sticky acc0", {63'h0, status_q[8]}, 64'h1);
    issue(1, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R8 clamp negative", {16'h0, acc_q}, 64'hFFFF_8000_0000);
    issue(0, 0, 0, 0, 0, 0, 32'd1, 32'd1);
    check("R11 skipped", {16'h0, acc_q}, 64'h0000_7FFF_FFFF);
    check("R11 V kept", {63'h0, status_q[1]}, 64'h1);
    for (int k = 0; k < 300; k++) issue(2, 0, 0, 0, 0, 0, 32'h000B_504F, 32'h000B_504F);
    check("R8 sum overflow clamp", {16'h0, acc_q}, 64'h0000_7FFF_FFFF);
    check("R8 sum overflow sticky", {63'h0, status_q[10]}, 64'h1);

    // Fractional mode
    do_reset();
    set_mode(4'b0011);
    issue(0, 0, 0, 0, 0, 0, 32'h0080_0000, 32'd1);
    check("R6 tie to even low", {16'h0, acc_q}, 64'd0);
    issue(1, 0, 0, 0, 0, 0, 32'h0180_0000, 32'd1);
    check("R6 tie to even up", {16'h0, acc_q}, 64'd2);
    issue(3, 0, 0, 0, 0, 1, 32'h0100_0000, 32'd1);
    check("R7 no shift in fraction", {16'h0, acc_q}, 64'd1);
    set_mode(4'b0010);
    issue(2, 0, 0, 0, 0, 0, 32'h0180_0000, 32'd1);
    check("R6 no rounding", {16'h0, acc_q}, 64'd1);
    set_mode(4'b0011);
    issue(2, 0, 0, 0, 0, 0, 32'h0180_0001, 32'd1);
    check("R6 above half", {16'h0, acc_q}, 64'd3);
    issue(3, 0, 1, 1, 0, 0, 32'h4000_0000, 32'h0000_4000);
    check("R3 fraction halves", {16'h0, acc_q}, 64'h0010_0000_0001);
    set_mode(4'b1010);
    for (int k = 0; k < 600; k++) issue(0, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check("R9 fraction clamp", {16'h0, acc_q}, 64'h7FFF_FFFF_FFFF);
    check("R9 flags", {60'h0, status_q[3:0]}, 64'h3);

    // Unsigned with and without saturation
    do_reset();
    set_mode(4'b1000);
    issue(0, 1, 0, 0, 0, 0, 32'd5, 32'd1);
    check("R10 underflow to zero", {16'h0, acc_q}, 64'd0);
    check("R10 sticky", {63'h0, status_q[8]}, 64'h1);
    issue(1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R10 clamp all ones", {16'h0, acc_q}, 64'hFFFF_FFFF_FFFF);
    check("R4 forced flags", {60'h0, status_q[3:0]}, 64'hB);
    set_mode(4'b0000);
    issue(2, 0, 0, 0, 0, 0, 32'd2, 32'd3);
    issue(2, 1, 0, 0, 0, 0, 32'd7, 32'd1);
    check("R10 wrap", {16'h0, acc_q}, 64'hFFFF_FFFF_FFFF);
    check("R10 wrap V", {63'h0, status_q[1]}, 64'h1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule